// File: doc/BRIEF.md
# Variable-Length Bit-Field Shifter

This block holds a 64-bit register and, on command, shifts the low part of that register (a field whose length is given at run time) toward the bottom or toward the top of the field. Positions that the shift vacates are filled with zeros. The last bit pushed out of the field is captured in a carry flag. Register bits at or above the field length take no part in the shift and keep their values.

The requested shift count is a 16-bit unsigned value. It is reduced modulo the field length before use. A zero field length, a zero count, a zero remainder, or a field length above the register width leaves everything untouched and raises a one-cycle skip pulse in place of the done pulse. A separate load port writes the whole register. The execute input works in one of two ways, selected per cycle. In level mode an operation runs on every clock while execute is high. In pulse mode one operation runs per rising edge of execute.

Top module: `bfs_shifter`

## Requirements
- R1: When `load_en` is high at a clock edge, `field_q` takes `load_data` on all 64 bits, `done_o` and `skip_o` are low in the following cycle, and no shift happens even if execute fires in that cycle.
- R2: A right shift (`dir_left`=0) with effective shift s moves field bit i+s to bit i for i < len-s, and writes zero to field bits len-s up to len-1. The result is visible, and `done_o` is high, in the cycle after the triggering edge.
- R3: A left shift (`dir_left`=1) with effective shift s moves field bit i-s to bit i for s <= i < len, and writes zero to field bits 0 up to s-1.
- R4: The effective shift is `shift_cnt` modulo `field_len`, so a count at or above the length behaves like its remainder.
- R5: If `field_len` is 0, or `field_len` is above 64, or `shift_cnt` is 0, or the remainder is 0, then `skip_o` pulses, `done_o` stays low, and `field_q` and `carry_q` keep their values.
- R6: Register bits at index `field_len` and above are never changed by a shift.
- R7: On a completed shift, `carry_q` becomes the old field bit s-1 for a right shift, or the old field bit len-s for a left shift.
- R8: With `pulse_mode`=0, an operation runs at every edge where `exec` is high, so holding `exec` high for k cycles applies k shifts.
- R9: With `pulse_mode`=1, an operation runs only at an edge where `exec` is high and was low at the previous edge.
- R10: After reset, `field_q`, `carry_q`, `done_o` and `skip_o` are zero, and `exec` being high at the first edge after reset counts as a rising edge. `done_o` and `skip_o` are never high together, and each lasts one cycle per operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Write `load_data` into the register |
| load_data | input | 64 | Value to load |
| field_len | input | 16 | Field length in bits, valid 1 to 64 |
| shift_cnt | input | 16 | Requested shift count, unsigned |
| dir_left | input | 1 | 0 shifts toward bit 0, 1 shifts toward the field top |
| pulse_mode | input | 1 | 0 level-triggered, 1 rising-edge-triggered |
| exec | input | 1 | Execute command |
| field_q | output | 64 | Register contents |
| carry_q | output | 1 | Last bit shifted out |
| done_o | output | 1 | One-cycle pulse: shift performed |
| skip_o | output | 1 | One-cycle pulse: command taken but no shift |

## Verification
The embedded properties compare values across one clock. They therefore assume that `field_len`, `shift_cnt`, `dir_left` and `pulse_mode` are known, and that they stay constant from the edge that samples them until that edge's result has settled. The rising-edge property also assumes the mode bit does not change between two neighbouring edges. The bench meets these assumptions by changing inputs only on the falling clock edge and holding `pulse_mode` fixed over blocks of many cycles. Random vectors mix field lengths from 0 to 70 and counts up to the full 16-bit range. This range hits the modulo wrap, the invalid lengths and the zero cases as well as ordinary shifts.

// File: rtl/bfs_pkg.sv
package bfs_pkg;

    localparam int unsigned DEF_FIELD_W = 64;
    localparam int unsigned DEF_LEN_W   = 16;
    localparam int unsigned DEF_CNT_W   = 16;

    typedef enum logic {
        DIR_TOWARD_LSB = 1'b0,
        DIR_TOWARD_MSB = 1'b1
    } shift_dir_e;

    typedef struct packed {
        logic done;
        logic skip;
    } op_status_t;

    // Remainder by restoring long division, one quotient bit per step.
    function automatic logic [DEF_LEN_W-1:0] count_rem(
        input logic [DEF_CNT_W-1:0] num,
        input logic [DEF_LEN_W-1:0] den
    );
        logic [DEF_LEN_W:0] part;
        part = '0;
        for (int i = DEF_CNT_W - 1; i >= 0; i--) begin
            part = {part[DEF_LEN_W-1:0], num[i]};
            if (part >= {1'b0, den}) begin
                part = part - {1'b0, den};
            end
        end
        return part[DEF_LEN_W-1:0];
    endfunction

endpackage

// File: rtl/bfs_trigger.sv
module bfs_trigger (
    input  logic clk,
    input  logic rst,
    input  logic exec_i,
    input  logic pulse_mode_i,
    output logic fire_o
);
    logic exec_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            exec_seen <= 1'b0;
        end else begin
            exec_seen <= exec_i;
        end
    end

    always_comb begin
        if (pulse_mode_i) begin
            fire_o = exec_i && !exec_seen;
        end else begin
            fire_o = exec_i;
        end
    end
endmodule

// File: rtl/bfs_amount.sv
module bfs_amount
    import bfs_pkg::*;
#(
    parameter int unsigned FIELD_W = DEF_FIELD_W,
    parameter int unsigned SH_W    = $clog2(FIELD_W) + 1
) (
    input  logic [DEF_LEN_W-1:0] len_i,
    input  logic [DEF_CNT_W-1:0] cnt_i,
    output logic                 go_o,
    output logic [SH_W-1:0]      amt_o
);
    logic [DEF_LEN_W-1:0] rem;
    logic                 len_ok;

    always_comb begin
        len_ok = (len_i != '0) && (len_i <= DEF_LEN_W'(FIELD_W));
        rem    = count_rem(cnt_i, len_i);
        go_o   = len_ok && (cnt_i != '0) && (rem != '0);
        amt_o  = SH_W'(rem);
    end
endmodule

// File: rtl/bfs_core.sv
module bfs_core #(
    parameter int unsigned FIELD_W = 64,
    parameter int unsigned SH_W    = $clog2(FIELD_W) + 1
) (
    input  logic [FIELD_W-1:0] data_i,
    input  logic [SH_W-1:0]    len_i,
    input  logic [SH_W-1:0]    amt_i,
    input  logic               left_i,
    output logic [FIELD_W-1:0] mask_o,
    output logic [FIELD_W-1:0] result_o,
    output logic               carry_o
);
    localparam int unsigned IDX_W = $clog2(FIELD_W);

    logic [FIELD_W-1:0] inner;
    logic [FIELD_W-1:0] moved;
    logic [IDX_W-1:0]   out_idx;

    for (genvar g = 0; g < FIELD_W; g++) begin : g_mask
        assign mask_o[g] = (len_i > SH_W'(g));
    end

    always_comb begin
        inner = data_i & mask_o;
        if (left_i) begin
            moved   = (inner << amt_i) & mask_o;
            out_idx = IDX_W'(len_i - amt_i);
        end else begin
            moved   = inner >> amt_i;
            out_idx = IDX_W'(amt_i - SH_W'(1));
        end
        result_o = (data_i & ~mask_o) | moved;
        carry_o  = data_i[out_idx];
    end
endmodule

// File: rtl/bfs_shifter.sv
module bfs_shifter
    import bfs_pkg::*;
#(
    parameter int unsigned FIELD_W = DEF_FIELD_W,
    localparam int unsigned SH_W   = $clog2(FIELD_W) + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load_en,
    input  logic [FIELD_W-1:0]   load_data,
    input  logic [DEF_LEN_W-1:0] field_len,
    input  logic [DEF_CNT_W-1:0] shift_cnt,
    input  logic                 dir_left,
    input  logic                 pulse_mode,
    input  logic                 exec,
    output logic [FIELD_W-1:0]   field_q,
    output logic                 carry_q,
    output logic                 done_o,
    output logic                 skip_o
);
    shift_dir_e         dir;
    logic               fire;
    logic               go;
    logic [SH_W-1:0]    amt;
    logic [SH_W-1:0]    len_s;
    logic [FIELD_W-1:0] core_mask;
    logic [FIELD_W-1:0] core_res;
    logic               core_carry;
    op_status_t         stat;

    assign dir   = shift_dir_e'(dir_left);
    assign len_s = SH_W'(field_len);

    bfs_trigger u_trig (
        .clk          (clk),
        .rst          (rst),
        .exec_i       (exec),
        .pulse_mode_i (pulse_mode),
        .fire_o       (fire)
    );

    bfs_amount #(.FIELD_W(FIELD_W), .SH_W(SH_W)) u_amt (
        .len_i (field_len),
        .cnt_i (shift_cnt),
        .go_o  (go),
        .amt_o (amt)
    );

    bfs_core #(.FIELD_W(FIELD_W), .SH_W(SH_W)) u_core (
        .data_i   (field_q),
        .len_i    (len_s),
        .amt_i    (amt),
        .left_i   (dir == DIR_TOWARD_MSB),
        .mask_o   (core_mask),
        .result_o (core_res),
        .carry_o  (core_carry)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            field_q <= '0;
            carry_q <= 1'b0;
            stat    <= '0;
        end else begin
            stat <= '0;
            if (load_en) begin
                field_q <= load_data;
            end else if (fire) begin
                if (go) begin
                    field_q   <= core_res;
                    carry_q   <= core_carry;
                    stat.done <= 1'b1;
                end else begin
                    stat.skip <= 1'b1;
                end
            end
        end
    end

    assign done_o = stat.done;
    assign skip_o = stat.skip;

    assert_flags_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(done_o && skip_o));

    assert_load_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(load_en)) |->
            (!done_o && !skip_o && field_q == $past(load_data)));

    assert_skip_keeps_R5: assert property (@(posedge clk) disable iff (rst)
        skip_o |-> (field_q == $past(field_q) && carry_q == $past(carry_q)));

    assert_upper_kept_R6: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ((field_q & ~$past(core_mask)) == ($past(field_q) & ~$past(core_mask))));

    assert_zero_fill_R2: assert property (@(posedge clk) disable iff (rst)
        (done_o && !$past(dir_left)) |->
            (((field_q & $past(core_mask)) >> ($past(len_s) - $past(amt))) == '0));

    assert_pulse_once_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && pulse_mode && $past(pulse_mode) && exec && $past(exec) && !load_en)
            |=> !(done_o || skip_o));
endmodule

// File: tb/bfs_shifter_tb.sv
module bfs_shifter_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        load_en;
    logic [63:0] load_data;
    logic [15:0] field_len;
    logic [15:0] shift_cnt;
    logic        dir_left;
    logic        pulse_mode;
    logic        exec;
    logic [63:0] field_q;
    logic        carry_q;
    logic        done_o;
    logic        skip_o;

    int vectors = 0;
    int miscompares = 0;

    logic [63:0] m_field;
    logic        m_carry;
    logic        m_done;
    logic        m_skip;
    logic        m_exec_prev;

    always #10 clk = ~clk;

    bfs_shifter u_dut (
        .clk(clk), .rst(rst), .load_en(load_en), .load_data(load_data),
        .field_len(field_len), .shift_cnt(shift_cnt), .dir_left(dir_left),
        .pulse_mode(pulse_mode), .exec(exec), .field_q(field_q),
        .carry_q(carry_q), .done_o(done_o), .skip_o(skip_o)
    );

    task automatic model_edge();
        logic        fire;
        logic [63:0] nxt;
        int          len;
        int          s;
        fire = pulse_mode ? (exec && !m_exec_prev) : exec;
        if (rst) begin
            m_field = '0; m_carry = 0; m_done = 0; m_skip = 0; m_exec_prev = 0;
            return;
        end
        m_exec_prev = exec;
        m_done = 0;
        m_skip = 0;
        if (load_en) begin
            m_field = load_data;
        end else if (fire) begin
            len = int'(field_len);
            if (len == 0 || len > 64 || shift_cnt == 0 || (int'(shift_cnt) % len) == 0) begin
                m_skip = 1;
            end else begin
                s = int'(shift_cnt) % len;
                nxt = m_field;
                for (int i = 0; i < len; i++) begin
                    if (!dir_left) nxt[i] = (i + s < len) ? m_field[i + s] : 1'b0;
                    else           nxt[i] = (i >= s) ? m_field[i - s] : 1'b0;
                end
                m_carry = dir_left ? m_field[len - s] : m_field[s - 1];
                m_field = nxt;
                m_done = 1;
            end
        end
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        vectors++;
        if (field_q !== m_field || carry_q !== m_carry || done_o !== m_done || skip_o !== m_skip) begin
            miscompares++;
            $display("FAIL %s: got field=%h carry=%b done=%b skip=%b, expected field=%h carry=%b done=%b skip=%b",
                     tag, field_q, carry_q, done_o, skip_o, m_field, m_carry, m_done, m_skip);
        end
    endtask

    task automatic idle_inputs();
        load_en = 0; exec = 0;
    endtask

    task automatic do_load(input logic [63:0] v, input string tag);
        idle_inputs(); load_en = 1; load_data = v;
        step(tag);
        load_en = 0;
    endtask

    task automatic do_shift(input int len, input int cnt, input logic left, input string tag);
        field_len = 16'(len); shift_cnt = 16'(cnt); dir_left = left;
        exec = 1; load_en = 0;
        step(tag);
        exec = 0;
        step(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: got run still active, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        rst = 1; load_en = 0; load_data = '0; field_len = 16'd10; shift_cnt = 16'd4;
        dir_left = 0; pulse_mode = 0; exec = 0;
        m_exec_prev = 0;
        step("R10"); step("R10");
        rst = 0;
        step("R10");

        // R2 right shift, upper bits set to test R6
        do_load(64'hFFFF_FFFF_FFFF_FDF0, "R1");
        do_shift(10, 4, 0, "R2");
        do_load(64'hA5A5_0000_0000_03F7, "R6");
        do_shift(10, 4, 0, "R6");
        // R3 left shift and R7 carry
        do_load(64'h0000_0000_0000_0235, "R1");
        do_shift(10, 3, 1, "R3");
        do_shift(10, 1, 1, "R7");
        do_shift(10, 1, 0, "R7");
        // R4 modulo reduction
        do_load(64'h1234_5678_9ABC_DEF0, "R1");
        do_shift(10, 23, 0, "R4");
        do_shift(64, 65535, 1, "R4");
        // R5 skip cases
        do_shift(10, 10, 0, "R5");
        do_shift(10, 0, 1, "R5");
        do_shift(0, 5, 0, "R5");
        do_shift(65, 3, 0, "R5");
        do_shift(1, 7, 1, "R5");
        // full width
        do_load(64'h8000_0000_0000_0001, "R1");
        do_shift(64, 1, 0, "R7");
        do_load(64'h8000_0000_0000_0001, "R1");
        do_shift(64, 63, 1, "R7");
        // R1 load has priority over execute
        field_len = 16; shift_cnt = 2; dir_left = 0;
        load_en = 1; exec = 1; load_data = 64'hDEAD_BEEF_0BAD_F00D;
        step("R1");
        idle_inputs(); step("R1");
        // R8 level mode repeats
        pulse_mode = 0; field_len = 16; shift_cnt = 1; dir_left = 1;
        exec = 1;
        for (int k = 0; k < 4; k++) step("R8");
        exec = 0; step("R8");
        // R9 pulse mode fires once
        pulse_mode = 1; step("R9");
        exec = 1;
        for (int k = 0; k < 4; k++) step("R9");
        exec = 0; step("R9");
        exec = 1; step("R9");
        exec = 0; step("R9");
        // reset with exec held high: first edge after reset is a rising edge
        rst = 1; exec = 1; step("R10");
        rst = 0; step("R10"); step("R10");
        exec = 0; pulse_mode = 0; step("R10");

        // random mix
        for (int n = 0; n < 600; n++) begin
            if (n % 25 == 0) pulse_mode = $urandom_range(0, 1);
            load_en   = ($urandom_range(0, 7) == 0);
            load_data = {$urandom(), $urandom()};
            field_len = 16'($urandom_range(0, 70));
            case ($urandom_range(0, 3))
                0: shift_cnt = 16'($urandom_range(0, 3));
                1: shift_cnt = 16'($urandom_range(0, 70));
                2: shift_cnt = 16'($urandom_range(0, 300));
                default: shift_cnt = 16'($urandom());
            endcase
            dir_left = $urandom_range(0, 1);
            exec     = $urandom_range(0, 1);
            step(dir_left ? "R3" : "R2");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule